// File: doc/BRIEF.md
# Upward-Growing Hardware Stack Pointer

This block keeps an 8-bit stack pointer together with a 128-byte on-chip data RAM and carries out the stack operations a processor core asks for. Single bytes go on and come off the stack through the push and pop strobes. The call and return strobes save or restore a 16-bit program counter as two consecutive bytes. The stack grows toward higher addresses. The pointer is incremented before every write, so after reset the pointer reads 07h and the first byte stored goes to address 08h.

Software can read the pointer at any time through a special-function-register port. It can also write the pointer, which moves the stack to any place in the RAM. Each operation takes a fixed number of cycles and ends with a one-cycle done pulse.

An increment that would carry the pointer past the last RAM address (7Fh) is refused and sets a sticky overflow flag. A decrement from 00h is refused in the same way and sets a sticky underflow flag. Writing the pointer clears both flags.

Top module: `stk_ptr_unit`

## Requirements
- R1: After synchronous reset, the pointer reads 07h, both flags read 0 and the done output is low.
- R2: A push increments the pointer and then writes the data byte at the new pointer value. Done is high in the first cycle after the accepting edge, and the first push after reset stores its byte at 08h.
- R3: A pop returns the byte at the current pointer and then decrements the pointer. The read data and done are valid in the second cycle after the accepting edge.
- R4: A call stores PC bits 7:0 at pointer+1 and PC bits 15:8 at pointer+2, and leaves the pointer two higher. Done is high in the second cycle after the accepting edge.
- R5: A return pops the high PC byte first and then the low byte, and leaves the pointer two lower. The PC output and done are valid in the third cycle after the accepting edge.
- R6: An increment requested while the pointer is 7Fh or above leaves the pointer unchanged, skips the RAM write and sets the overflow flag.
- R7: A decrement requested while the pointer is 00h leaves the pointer at 00h and sets the underflow flag.
- R8: A pointer write loads the written value on the next edge and clears both flags. The read port always shows the current pointer.
- R9: A pointer write in the same cycle as an operation request in the idle state wins. The request is dropped: there is no done pulse, no RAM write and no pointer step.
- R10: When several requests arrive together in the idle state, call wins over return, return over push, and push over pop. Requests that arrive while an operation is in progress are ignored.
- R11: A stack based anywhere in the 128-byte RAM returns its contents in last-in, first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_req | input | 1 | Push one byte |
| pop_req | input | 1 | Pop one byte |
| call_req | input | 1 | Save the program counter |
| ret_req | input | 1 | Restore the program counter |
| wr_data | input | 8 | Byte to push |
| rd_data | output | 8 | Byte popped, registered |
| pc_in | input | 16 | Program counter to save |
| pc_out | output | 16 | Program counter restored, registered |
| sfr_we | input | 1 | Software write strobe for the pointer |
| sfr_wdata | input | 8 | Value written to the pointer |
| sfr_rdata | output | 8 | Current pointer value |
| op_done | output | 1 | One-cycle completion pulse |
| ovf_flag | output | 1 | Sticky overflow flag |
| udf_flag | output | 1 | Sticky underflow flag |

## Verification
The pointer is visible on the read port in every cycle, so a wrong increment or decrement shows up one edge after the step that caused it. A misplaced RAM write, or a call or return that puts its bytes in the wrong order, stays hidden until the affected byte is popped. For that reason the bench fills the whole RAM, drains it, and runs call and return at many stack bases. A sequencer fault appears as a done pulse arriving in the wrong cycle, which the bench catches on the operation where it happens.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CALL_HI = 3'd1,
    ST_POP_OUT = 3'd2,
    ST_RET_LO  = 3'd3,
    ST_RET_OUT = 3'd4
  } stk_state_t;
endpackage

// File: rtl/stk_ram.sv
module stk_ram #(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // single port, read-first, synchronous read for block RAM inference
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    q <= mem[addr];
  end
endmodule

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter int             PW      = 8,
  parameter int             AW      = 7,
  parameter logic [PW-1:0]  RST_VAL = 8'h07
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sfr_we,
  input  logic [PW-1:0] sfr_wdata,
  input  logic          step_inc,
  input  logic          step_dec,
  output logic [PW-1:0] sp_q,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] up_addr,
  output logic          ovf_hit,
  output logic          udf_hit,
  output logic          ovf_flag,
  output logic          udf_flag
);
  localparam logic [PW-1:0] TOP = PW'((1 << AW) - 1);

  logic [PW-1:0] sp_up;
  logic [PW-1:0] sp_dn;

  assign sp_up    = sp_q + PW'(1);
  assign sp_dn    = sp_q - PW'(1);
  assign ovf_hit  = (sp_q >= TOP);
  assign udf_hit  = (sp_q == '0);
  assign cur_addr = sp_q[AW-1:0];
  assign up_addr  = sp_up[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q     <= RST_VAL;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else if (sfr_we) begin
      sp_q     <= sfr_wdata;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else if (step_inc) begin
      if (ovf_hit) ovf_flag <= 1'b1;
      else         sp_q     <= sp_up;
    end else if (step_dec) begin
      if (udf_hit) udf_flag <= 1'b1;
      else         sp_q     <= sp_dn;
    end
  end

  // R2: a legal increment moves the pointer up by exactly one
  a_r2_pre_increment: assert property (@(posedge clk) disable iff (rst)
    (step_inc && !ovf_hit && !sfr_we) |=> (sp_q == $past(sp_q) + PW'(1)));

  // R6: an increment at the top holds the pointer and raises the flag
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (step_inc && ovf_hit && !sfr_we) |=> ($stable(sp_q) && ovf_flag));

  // R7: a decrement at zero holds the pointer and raises the flag
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (step_dec && udf_hit && !sfr_we && !step_inc) |=> (sp_q == '0 && udf_flag));

  // R8: software write loads the pointer and clears flags
  a_r8_sfr_load: assert property (@(posedge clk) disable iff (rst)
    sfr_we |=> (sp_q == $past(sfr_wdata) && !ovf_flag && !udf_flag));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic            call_req,
  input  logic            ret_req,
  input  logic            sfr_we,
  input  logic [DW-1:0]   wr_data,
  input  logic [2*DW-1:0] pc_in,
  input  logic [AW-1:0]   cur_addr,
  input  logic [AW-1:0]   up_addr,
  input  logic            ovf_hit,
  input  logic [DW-1:0]   ram_q,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [DW-1:0]   ram_wdata,
  output logic            step_inc,
  output logic            step_dec,
  output logic [DW-1:0]   rd_data,
  output logic [2*DW-1:0] pc_out,
  output logic            op_done
);
  stk_state_t    state_q, state_d;
  logic          done_d;
  logic          take_call;
  logic [DW-1:0] pc_hi_hold;
  logic [DW-1:0] ret_hi_q;

  assign take_call = (state_q == ST_IDLE) && !sfr_we && call_req;

  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = cur_addr;
    ram_wdata = wr_data;
    step_inc  = 1'b0;
    step_dec  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (!sfr_we) begin
          if (call_req) begin
            step_inc  = 1'b1;
            ram_we    = !ovf_hit;
            ram_addr  = up_addr;
            ram_wdata = pc_in[DW-1:0];
            state_d   = ST_CALL_HI;
          end else if (ret_req) begin
            step_dec = 1'b1;
            state_d  = ST_RET_LO;
          end else if (push_req) begin
            step_inc  = 1'b1;
            ram_we    = !ovf_hit;
            ram_addr  = up_addr;
            ram_wdata = wr_data;
            done_d    = 1'b1;
          end else if (pop_req) begin
            step_dec = 1'b1;
            state_d  = ST_POP_OUT;
          end
        end
      end
      ST_CALL_HI: begin
        step_inc  = 1'b1;
        ram_we    = !ovf_hit;
        ram_addr  = up_addr;
        ram_wdata = pc_hi_hold;
        done_d    = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_POP_OUT: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      ST_RET_LO: begin
        step_dec = 1'b1;
        state_d  = ST_RET_OUT;
      end
      ST_RET_OUT: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      op_done    <= 1'b0;
      rd_data    <= '0;
      pc_out     <= '0;
      pc_hi_hold <= '0;
      ret_hi_q   <= '0;
    end else begin
      state_q <= state_d;
      op_done <= done_d;
      if (take_call)              pc_hi_hold <= pc_in[2*DW-1:DW];
      if (state_q == ST_POP_OUT)  rd_data    <= ram_q;
      if (state_q == ST_RET_LO)   ret_hi_q   <= ram_q;
      if (state_q == ST_RET_OUT)  pc_out     <= {ret_hi_q, ram_q};
    end
  end

  // R10: completion is only signalled back in the idle state
  a_r10_done_in_idle: assert property (@(posedge clk) disable iff (rst)
    op_done |-> (state_q == ST_IDLE));

  // R9: a software write in idle blocks any operation start
  a_r9_sfr_blocks_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && sfr_we) |=> (!op_done && state_q == ST_IDLE));

  // R4: the second call step always finishes the call
  a_r4_call_two_steps: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CALL_HI) |=> (op_done && state_q == ST_IDLE));

  // R5: the high-byte read of a return is followed by the output step
  a_r5_ret_order: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RET_LO) |=> (state_q == ST_RET_OUT && !op_done));
endmodule

// File: rtl/stk_ptr_unit.sv
module stk_ptr_unit #(
  parameter int            DW      = 8,
  parameter int            AW      = 7,
  parameter logic [DW-1:0] RST_VAL = 8'h07
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_req,
  input  logic            pop_req,
  input  logic            call_req,
  input  logic            ret_req,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic [2*DW-1:0] pc_in,
  output logic [2*DW-1:0] pc_out,
  input  logic            sfr_we,
  input  logic [DW-1:0]   sfr_wdata,
  output logic [DW-1:0]   sfr_rdata,
  output logic            op_done,
  output logic            ovf_flag,
  output logic            udf_flag
);
  logic          step_inc, step_dec;
  logic          ovf_hit, udf_hit;
  logic [AW-1:0] cur_addr, up_addr;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata, ram_q;
  logic [DW-1:0] sp_q;

  stk_ptr_reg #(.PW(DW), .AW(AW), .RST_VAL(RST_VAL)) u_ptr (
    .clk(clk), .rst(rst), .sfr_we(sfr_we), .sfr_wdata(sfr_wdata),
    .step_inc(step_inc), .step_dec(step_dec), .sp_q(sp_q),
    .cur_addr(cur_addr), .up_addr(up_addr), .ovf_hit(ovf_hit),
    .udf_hit(udf_hit), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  stk_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .call_req(call_req), .ret_req(ret_req), .sfr_we(sfr_we),
    .wr_data(wr_data), .pc_in(pc_in), .cur_addr(cur_addr),
    .up_addr(up_addr), .ovf_hit(ovf_hit), .ram_q(ram_q),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .step_inc(step_inc), .step_dec(step_dec), .rd_data(rd_data),
    .pc_out(pc_out), .op_done(op_done)
  );

  stk_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .q(ram_q)
  );

  assign sfr_rdata = sp_q;

  // R6: the RAM is never written while the pointer sits at the top
  a_r6_write_suppressed: assert property (@(posedge clk) disable iff (rst)
    (ovf_hit && step_inc) |-> !ram_we);

  // R7: underflow flag only rises on a decrement attempt at zero
  a_r7_udf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(udf_flag) |-> ($past(udf_hit) && $past(step_dec)));
endmodule

// File: tb/stk_ptr_unit_test.sv
`timescale 1ns/1ps
module stk_ptr_unit_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        push_req, pop_req, call_req, ret_req, sfr_we;
  logic [7:0]  wr_data, sfr_wdata, rd_data, sfr_rdata;
  logic [15:0] pc_in, pc_out;
  logic        op_done, ovf_flag, udf_flag;

  int n_vec = 0;
  int n_bad = 0;

  logic [7:0] mem [128];
  bit         vld [128];
  logic [7:0] msp;
  bit         movf, mudf;

  stk_ptr_unit uut (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
    .call_req(call_req), .ret_req(ret_req), .wr_data(wr_data),
    .rd_data(rd_data), .pc_in(pc_in), .pc_out(pc_out), .sfr_we(sfr_we),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .op_done(op_done),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    push_req = 0; pop_req = 0; call_req = 0; ret_req = 0; sfr_we = 0;
  endtask

  // model steps derived from the requirements
  task automatic m_push(input logic [7:0] d);
    if (msp >= 8'h7F) movf = 1;
    else begin msp = msp + 1; mem[msp[6:0]] = d; vld[msp[6:0]] = 1; end
  endtask

  task automatic m_pop(output logic [7:0] d, output bit known);
    d = mem[msp[6:0]]; known = vld[msp[6:0]];
    if (msp == 8'h00) mudf = 1; else msp = msp - 1;
  endtask

  task automatic chk_state(input string req);
    chk({req, " pointer"}, sfr_rdata, msp);
    chk({req, " ovf"}, ovf_flag, movf);
    chk({req, " udf"}, udf_flag, mudf);
  endtask

  // kind: 0 push, 1 pop, 2 call, 3 ret ; returns sampled in done cycle
  task automatic run_op(input int kind, input logic [7:0] d, input logic [15:0] pc, input string req);
    int lat;
    lat = (kind == 0) ? 1 : (kind == 3) ? 3 : 2;
    @(negedge clk);
    push_req = (kind == 0); pop_req = (kind == 1);
    call_req = (kind == 2); ret_req = (kind == 3);
    wr_data = d; pc_in = pc;
    @(negedge clk);
    idle_inputs();
    for (int i = 1; i <= lat; i++) begin
      if (i > 1) @(negedge clk);
      if (i < lat && op_done) chk({req, " early done"}, op_done, 0);
    end
    chk({req, " done latency"}, op_done, 1);
  endtask

  task automatic sfr_write(input logic [7:0] v);
    @(negedge clk);
    sfr_we = 1; sfr_wdata = v;
    @(negedge clk);
    sfr_we = 0;
    msp = v; movf = 0; mudf = 0;
  endtask

  task automatic do_push(input logic [7:0] d, input string req);
    run_op(0, d, 16'h0, req);
    m_push(d);
    chk_state(req);
  endtask

  task automatic do_pop(input string req);
    logic [7:0] e; bit k;
    run_op(1, 8'h00, 16'h0, req);
    m_pop(e, k);
    if (k) chk({req, " data"}, rd_data, e);
    chk_state(req);
  endtask

  task automatic do_call(input logic [15:0] pc, input string req);
    run_op(2, 8'h00, pc, req);
    m_push(pc[7:0]); m_push(pc[15:8]);
    chk_state(req);
  endtask

  task automatic do_ret(input string req);
    logic [7:0] h, l; bit kh, kl;
    run_op(3, 8'h00, 16'h0, req);
    m_pop(h, kh); m_pop(l, kl);
    if (kh && kl) chk({req, " pc"}, pc_out, {h, l});
    chk_state(req);
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) vld[i] = 0;
    idle_inputs();
    wr_data = 0; sfr_wdata = 0; pc_in = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    msp = 8'h07; movf = 0; mudf = 0;
    // R1 reset state
    chk("R1 pointer", sfr_rdata, 8'h07);
    chk("R1 ovf", ovf_flag, 0);
    chk("R1 udf", udf_flag, 0);
    chk("R1 done", op_done, 0);

    // R2 first push lands at 08h, R3 pop returns it
    do_push(8'hA5, "R2");
    do_pop("R3");

    // R11 fill the whole RAM upward, R6 at the top
    for (int a = 8; a < 128; a++) do_push(8'(a) ^ 8'h5A, "R11 fill");
    do_push(8'hEE, "R6 push at top");
    do_call(16'hBEEF, "R6 call at top");
    for (int a = 127; a >= 8; a--) do_pop("R11 drain");

    // R8 write clears flags; R7 underflow at zero
    sfr_write(8'h00);
    chk_state("R8");
    do_pop("R7 pop at zero");
    do_ret("R7 ret at zero");

    // R11 / R4 / R5 call-return at many bases
    for (int b = 0; b < 126; b += 5) begin
      sfr_write(8'(b));
      do_call(16'(b * 517 + 16'h1234), "R4 call");
      do_ret("R5 ret");
    end
    // R4 byte order: high byte on top, low below
    sfr_write(8'h40);
    do_call(16'hC3A7, "R4 order");
    do_pop("R4 high byte");
    chk("R4 high value", rd_data, 8'hC3);
    do_pop("R4 low byte");
    chk("R4 low value", rd_data, 8'hA7);

    // R6 call straddling the top
    sfr_write(8'h7E);
    do_call(16'h9D31, "R6 call straddle");
    do_pop("R6 top byte");
    chk("R6 low kept", rd_data, 8'h31);

    // R9 software write beats a same-cycle push
    sfr_write(8'h20);
    @(negedge clk);
    sfr_we = 1; sfr_wdata = 8'h30; push_req = 1; wr_data = 8'h11;
    @(negedge clk);
    idle_inputs();
    chk("R9 no done", op_done, 0);
    msp = 8'h30; movf = 0; mudf = 0;
    chk_state("R9");
    @(negedge clk);
    chk("R9 still no done", op_done, 0);
    do_pop("R9 untouched RAM");

    // R10 priority push over pop
    sfr_write(8'h50);
    @(negedge clk);
    push_req = 1; pop_req = 1; wr_data = 8'h77;
    @(negedge clk);
    idle_inputs();
    chk("R10 push wins done", op_done, 1);
    m_push(8'h77);
    chk_state("R10 push wins");
    // R10 call over push and ret over pop
    @(negedge clk);
    call_req = 1; push_req = 1; ret_req = 1; pc_in = 16'h4321; wr_data = 8'h99;
    @(negedge clk);
    idle_inputs();
    chk("R10 call not done yet", op_done, 0);
    push_req = 1; wr_data = 8'h66;   // arrives while busy, ignored
    @(negedge clk);
    idle_inputs();
    chk("R10 call done", op_done, 1);
    m_push(8'h21); m_push(8'h43);
    chk_state("R10 call wins");
    @(negedge clk);
    chk("R10 busy push ignored", op_done, 0);
    chk_state("R10 busy push ignored");
    @(negedge clk);
    ret_req = 1; pop_req = 1;
    @(negedge clk);
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    chk("R10 ret wins done", op_done, 1);
    chk("R10 ret pc", pc_out, 16'h4321);
    msp = msp - 2;
    chk_state("R10 ret wins");
    do_pop("R10 after ret");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule